// File: doc/BRIEF.md
# Distributed and Self-Refresh Scheduler for an EDO DRAM

This block keeps an asynchronous EDO DRAM refreshed. An interval timer marks each slot in which one CAS-before-RAS refresh is due. The block counts these slots as owed refreshes and asks the access sequencer for the memory through a request/grant pair. Once granted, it drives the two strobes through a complete refresh cycle: CAS falls first, RAS follows, and both are then held high for precharge. The DRAM takes the row from its own internal counter. With 4,096 cycles spread over 64 ms the array is covered whether it has 4K or 8K rows, because the 8K-row die refreshes two rows per cycle. At the default 15.625 µs spacing the interval parameter is 781 cycles of a 50 MHz clock. An extended-interval input doubles the spacing, for parts rated for a 128 ms period.

The block can also put the DRAM into self refresh. On a granted entry request it runs a refresh cycle and then keeps both strobes low for at least the minimum hold. It stays in self refresh until an exit request arrives. On exit it holds both strobes high for the minimum exit time. If the controller refreshes in bursts rather than distributed, a configuration input adds a catch-up burst of back-to-back refresh cycles before the memory is handed back. All times are counted in system-clock cycles.

Top module: `refresh_sched`

## Requirements
- R1: With the extended input low, one refresh becomes owed every INTERVAL clocks after reset. The first becomes owed at the edge that ends clock INTERVAL, and `req` rises while the block is idle.
- R2: With `ext_mode` high, the spacing between owed refreshes is 2×INTERVAL clocks.
- R3: A refresh cycle drives `cas_n` low with `ras_n` high for CAS_LEAD clocks. Both strobes are then low for RAS_LOW clocks, then both are high for PRECHARGE clocks. `ras_n` never falls unless `cas_n` was already low on the clock before.
- R4: While idle, `req` is high exactly when a refresh is owed or `sr_enter_req` is high. While any sequence runs, `req` stays high. `grant` is acted on only when the block is idle and `req` is high.
- R5: Each refresh that is not granted stays owed. Each completed refresh cycle retires one owed refresh. The owed count never exceeds OWED_MAX.
- R6: `owed_ovf` goes high when a slot arrives while OWED_MAX refreshes are already owed. It then stays high until reset.
- R7: If `sr_enter_req` and an owed refresh are both present at a grant, self-refresh entry is taken. The entry runs the CAS-lead phase and then holds both strobes low for SELF_HOLD clocks. `sr_exit_req` is ignored during that hold.
- R8: After the hold, both strobes stay low until `sr_exit_req` is seen high. Both are then high for SELF_EXIT clocks. Owed refreshes are cleared on entry, and no slot accrues from the hold through the exit.
- R9: `mode` reads 0 in normal operation and 1 while entering self refresh (CAS-lead phase and hold). It reads 2 while in self refresh and 3 while leaving (exit time and any catch-up burst).
- R10: If `burst_after_exit` is high when the exit time ends, BURST_LEN refresh cycles run back to back without a new grant, each in the R3 form. The block then goes idle. If it is low, the block goes idle directly.
- R11: During and right after reset, `ras_n` and `cas_n` are high, `req` is low, `mode` is 0 and `owed_ovf` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_mode | input | 1 | Doubles the refresh spacing |
| burst_after_exit | input | 1 | Run a catch-up burst after self-refresh exit |
| sr_enter_req | input | 1 | Request to enter self refresh |
| sr_exit_req | input | 1 | Request to leave self refresh |
| grant | input | 1 | Access sequencer hands the DRAM to this block |
| req | output | 1 | This block wants or holds the DRAM |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| mode | output | 2 | Self-refresh status (R9 encoding) |
| owed_ovf | output | 1 | Sticky owed-refresh overflow |

## Verification
The assertions assume that every timing parameter is at least one clock and that the inputs change only between clock edges. They also assume that `grant` means something only while `req` is high. The stimulus changes inputs a fixed delay after the falling edge. It holds `sr_enter_req` until `mode` leaves 0, so no entry request is lost to a cycle that is already running. It raises `sr_exit_req` once during the entry hold and once in self refresh, so both the ignored and the honoured exit are seen. The grant is withheld long enough to saturate the owed count and is withdrawn during the catch-up burst.

// File: rtl/rsched_pkg.sv
package rsched_pkg;
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_LEAD   = 3'd1,
        ST_STROBE = 3'd2,
        ST_PRECH  = 3'd3,
        ST_SRHOLD = 3'd4,
        ST_SRON   = 3'd5,
        ST_SREXIT = 3'd6
    } seq_state_e;

    typedef enum logic [1:0] {
        MODE_NORMAL = 2'd0,
        MODE_ENTRY  = 2'd1,
        MODE_SELF   = 2'd2,
        MODE_LEAVE  = 2'd3
    } sr_mode_e;
endpackage

// File: rtl/rsched_timer.sv
module rsched_timer #(
    parameter int INTERVAL = 781
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_mode,
    output logic tick
);
    localparam int CW = $clog2(2 * INTERVAL + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t r_d, r_q;
    logic [CW-1:0] limit;

    always_comb begin
        r_d   = r_q;
        limit = ext_mode ? CW'(2 * INTERVAL - 1) : CW'(INTERVAL - 1);
        tick  = (r_q.cnt >= limit);
        if (tick) r_d.cnt = '0;
        else      r_d.cnt = r_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end
endmodule

// File: rtl/rsched_owed.sv
module rsched_owed #(
    parameter int OWED_MAX = 8,
    localparam int OW = $clog2(OWED_MAX + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          tick_en,
    input  logic          done,
    input  logic          clear,
    output logic [OW-1:0] owed,
    output logic          pending,
    output logic          ovf
);
    typedef struct packed {
        logic [OW-1:0] owed;
        logic          ovf;
    } owed_t;

    owed_t r_d, r_q;
    logic [OW:0] sum;

    always_comb begin
        r_d = r_q;
        sum = {1'b0, r_q.owed} + {{OW{1'b0}}, (tick & tick_en)};
        if (done && sum != '0) sum = sum - 1'b1;
        if (sum > (OW+1)'(OWED_MAX)) begin
            sum     = (OW+1)'(OWED_MAX);
            r_d.ovf = 1'b1;
        end
        r_d.owed = clear ? '0 : sum[OW-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign owed    = r_q.owed;
    assign pending = (r_q.owed != '0);
    assign ovf     = r_q.ovf;

    assert_owed_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.owed <= OW'(OWED_MAX));
    assert_ovf_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.ovf |=> r_q.ovf);
endmodule

// File: rtl/rsched_fsm.sv
module rsched_fsm
    import rsched_pkg::*;
#(
    parameter int CAS_LEAD  = 1,
    parameter int RAS_LOW   = 4,
    parameter int PRECHARGE = 3,
    parameter int SELF_HOLD = 5000,
    parameter int SELF_EXIT = 6,
    parameter int BURST_LEN = 4096
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pending,
    input  logic       sr_enter_req,
    input  logic       sr_exit_req,
    input  logic       grant,
    input  logic       burst_after_exit,
    output logic       req,
    output logic       ras_n,
    output logic       cas_n,
    output sr_mode_e   mode,
    output logic       cbr_done,
    output logic       sr_clear,
    output logic       in_self
);
    localparam int M1   = (CAS_LEAD > RAS_LOW) ? CAS_LEAD : RAS_LOW;
    localparam int M2   = (PRECHARGE > M1) ? PRECHARGE : M1;
    localparam int M3   = (SELF_HOLD > M2) ? SELF_HOLD : M2;
    localparam int MAXL = (SELF_EXIT > M3) ? SELF_EXIT : M3;
    localparam int TW   = $clog2(MAXL + 1);
    localparam int BW   = $clog2(BURST_LEN + 1);

    typedef struct packed {
        seq_state_e    st;
        logic [TW-1:0] tmr;
        logic [BW-1:0] burst;
        logic          srf;
    } fsm_t;

    fsm_t r_d, r_q;
    logic [TW-1:0] tmr_inc;

    always_comb begin
        r_d      = r_q;
        cbr_done = 1'b0;
        sr_clear = 1'b0;
        tmr_inc  = r_q.tmr + 1'b1;
        r_d.tmr  = tmr_inc;
        unique case (r_q.st)
            ST_IDLE: begin
                r_d.tmr = '0;
                if (grant && (sr_enter_req || pending)) begin
                    r_d.st  = ST_LEAD;
                    r_d.srf = sr_enter_req;
                end
            end
            ST_LEAD: begin
                if (r_q.tmr == TW'(CAS_LEAD - 1)) begin
                    r_d.tmr = '0;
                    if (r_q.srf) begin
                        r_d.st   = ST_SRHOLD;
                        sr_clear = 1'b1;
                    end else begin
                        r_d.st = ST_STROBE;
                    end
                end
            end
            ST_STROBE: begin
                if (r_q.tmr == TW'(RAS_LOW - 1)) begin
                    r_d.tmr = '0;
                    r_d.st  = ST_PRECH;
                end
            end
            ST_PRECH: begin
                if (r_q.tmr == TW'(PRECHARGE - 1)) begin
                    r_d.tmr  = '0;
                    cbr_done = 1'b1;
                    if (r_q.burst > BW'(1)) begin
                        r_d.burst = r_q.burst - 1'b1;
                        r_d.st    = ST_LEAD;
                    end else begin
                        r_d.burst = '0;
                        r_d.st    = ST_IDLE;
                    end
                end
            end
            ST_SRHOLD: begin
                if (r_q.tmr == TW'(SELF_HOLD - 1)) begin
                    r_d.tmr = '0;
                    r_d.st  = ST_SRON;
                end
            end
            ST_SRON: begin
                r_d.tmr = '0;
                if (sr_exit_req) r_d.st = ST_SREXIT;
            end
            ST_SREXIT: begin
                if (r_q.tmr == TW'(SELF_EXIT - 1)) begin
                    r_d.tmr = '0;
                    r_d.srf = 1'b0;
                    if (burst_after_exit && BURST_LEN > 0) begin
                        r_d.burst = BW'(BURST_LEN);
                        r_d.st    = ST_LEAD;
                    end else begin
                        r_d.st = ST_IDLE;
                    end
                end
            end
            default: r_d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        ras_n   = !(r_q.st inside {ST_STROBE, ST_SRHOLD, ST_SRON});
        cas_n   = !(r_q.st inside {ST_LEAD, ST_STROBE, ST_SRHOLD, ST_SRON});
        in_self = (r_q.st inside {ST_SRHOLD, ST_SRON, ST_SREXIT});
        req     = (r_q.st != ST_IDLE) || pending || sr_enter_req;
        if (r_q.st == ST_SRHOLD || (r_q.st == ST_LEAD && r_q.srf)) mode = MODE_ENTRY;
        else if (r_q.st == ST_SRON)                                 mode = MODE_SELF;
        else if (r_q.st == ST_SREXIT || r_q.burst != '0)            mode = MODE_LEAVE;
        else                                                        mode = MODE_NORMAL;
    end

    assert_cas_before_ras_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> (!cas_n && !$past(cas_n)));
    assert_req_while_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st != ST_IDLE) |-> req);
    assert_self_strobes_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_SELF) |-> (!ras_n && !cas_n));
    assert_exit_from_self_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode) == MODE_SELF && mode != MODE_SELF) |-> (mode == MODE_LEAVE && ras_n && cas_n));
endmodule

// File: rtl/refresh_sched.sv
module refresh_sched
    import rsched_pkg::*;
#(
    parameter int INTERVAL  = 781,
    parameter int CAS_LEAD  = 1,
    parameter int RAS_LOW   = 4,
    parameter int PRECHARGE = 3,
    parameter int SELF_HOLD = 5000,
    parameter int SELF_EXIT = 6,
    parameter int OWED_MAX  = 8,
    parameter int BURST_LEN = 4096
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ext_mode,
    input  logic       burst_after_exit,
    input  logic       sr_enter_req,
    input  logic       sr_exit_req,
    input  logic       grant,
    output logic       req,
    output logic       ras_n,
    output logic       cas_n,
    output logic [1:0] mode,
    output logic       owed_ovf
);
    localparam int OW = $clog2(OWED_MAX + 1);

    logic          tick, pending, cbr_done, sr_clear, in_self;
    logic [OW-1:0] owed;
    sr_mode_e      mode_e;

    rsched_timer #(.INTERVAL(INTERVAL)) u_timer (
        .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode), .tick(tick)
    );

    rsched_owed #(.OWED_MAX(OWED_MAX)) u_owed (
        .clk(clk), .rst_n(rst_n), .tick(tick), .tick_en(!in_self),
        .done(cbr_done), .clear(sr_clear), .owed(owed),
        .pending(pending), .ovf(owed_ovf)
    );

    rsched_fsm #(
        .CAS_LEAD(CAS_LEAD), .RAS_LOW(RAS_LOW), .PRECHARGE(PRECHARGE),
        .SELF_HOLD(SELF_HOLD), .SELF_EXIT(SELF_EXIT), .BURST_LEN(BURST_LEN)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .pending(pending),
        .sr_enter_req(sr_enter_req), .sr_exit_req(sr_exit_req),
        .grant(grant), .burst_after_exit(burst_after_exit),
        .req(req), .ras_n(ras_n), .cas_n(cas_n), .mode(mode_e),
        .cbr_done(cbr_done), .sr_clear(sr_clear), .in_self(in_self)
    );

    assign mode = mode_e;

    assert_no_owed_in_self_R8: assert property (@(posedge clk) disable iff (!rst_n)
        in_self |-> (owed == '0));
endmodule

// File: tb/refresh_sched_tb_top.sv
module refresh_sched_tb_top;
    localparam int P_INT = 20, P_LEAD = 2, P_RAS = 3, P_PRE = 2;
    localparam int P_HOLD = 6, P_EXIT = 4, P_MAX = 3, P_BURST = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic ext_mode = 0, burst_after_exit = 0, sr_enter_req = 0, sr_exit_req = 0, grant = 0;
    logic req, ras_n, cas_n, owed_ovf;
    logic [1:0] mode;

    int compared = 0, mismatched = 0, cycle = 0;

    always #10 clk = ~clk;

    refresh_sched #(
        .INTERVAL(P_INT), .CAS_LEAD(P_LEAD), .RAS_LOW(P_RAS), .PRECHARGE(P_PRE),
        .SELF_HOLD(P_HOLD), .SELF_EXIT(P_EXIT), .OWED_MAX(P_MAX), .BURST_LEN(P_BURST)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode), .burst_after_exit(burst_after_exit),
        .sr_enter_req(sr_enter_req), .sr_exit_req(sr_exit_req), .grant(grant),
        .req(req), .ras_n(ras_n), .cas_n(cas_n), .mode(mode), .owed_ovf(owed_ovf)
    );

    // Reference model: phases 0 idle,1 cas-lead,2 strobe,3 precharge,4 hold,5 self,6 exit
    int m_ph = 0, m_cnt = 0, m_owed = 0, m_ovf = 0, m_burst = 0, m_srf = 0, m_t = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_cnt = 0; m_owed = 0; m_ovf = 0; m_burst = 0; m_srf = 0; m_t = 0;
        end else begin
            int lim, nph, nowed;
            bit tk, done, clr;
            lim = ext_mode ? 2 * P_INT : P_INT;
            tk = (m_t >= lim - 1);
            m_t = tk ? 0 : m_t + 1;
            done = 0; clr = 0; nph = m_ph;
            case (m_ph)
                0: if (grant && (sr_enter_req || m_owed > 0)) begin nph = 1; m_srf = sr_enter_req; m_cnt = 0; end
                1: if (++m_cnt == P_LEAD) begin m_cnt = 0; if (m_srf) begin nph = 4; clr = 1; end else nph = 2; end
                2: if (++m_cnt == P_RAS) begin m_cnt = 0; nph = 3; end
                3: if (++m_cnt == P_PRE) begin
                       m_cnt = 0; done = 1;
                       if (m_burst > 1) begin m_burst--; nph = 1; end else begin m_burst = 0; nph = 0; end
                   end
                4: if (++m_cnt == P_HOLD) begin m_cnt = 0; nph = 5; end
                5: if (sr_exit_req) begin nph = 6; m_cnt = 0; end
                6: if (++m_cnt == P_EXIT) begin
                       m_cnt = 0; m_srf = 0;
                       if (burst_after_exit) begin m_burst = P_BURST; nph = 1; end else nph = 0;
                   end
                default: nph = 0;
            endcase
            nowed = m_owed + ((tk && !(m_ph >= 4)) ? 1 : 0);
            if (done && nowed > 0) nowed--;
            if (nowed > P_MAX) begin nowed = P_MAX; m_ovf = 1; end
            m_owed = clr ? 0 : nowed;
            m_ph = nph;
        end
    end

    task automatic check(string tag, string nm, int act, int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s %s at cycle %0d: actual %0d expected %0d", tag, nm, cycle, act, exp);
        end
    endtask

    always @(negedge clk) begin
        int e_ras, e_cas, e_req, e_mode;
        string st, rt;
        cycle++;
        e_ras = (m_ph == 2 || m_ph == 4 || m_ph == 5) ? 0 : 1;
        e_cas = (m_ph >= 1 && m_ph <= 5 && m_ph != 3) ? 0 : 1;
        e_req = (m_ph != 0 || m_owed > 0 || sr_enter_req) ? 1 : 0;
        if (m_ph == 4 || (m_ph == 1 && m_srf)) e_mode = 1;
        else if (m_ph == 5) e_mode = 2;
        else if (m_ph == 6 || m_burst > 0) e_mode = 3;
        else e_mode = 0;
        if (!rst_n || cycle < 8) st = "R11";
        else if (m_ph == 4 || (m_ph == 1 && m_srf)) st = "R7";
        else if (m_ph == 5 || m_ph == 6) st = "R8";
        else if (m_burst > 0) st = "R10";
        else st = "R3";
        if (!rst_n || cycle < 8) rt = "R11";
        else if (m_ph != 0) rt = "R4";
        else if (ext_mode) rt = "R2";
        else if (m_owed > 1) rt = "R5";
        else rt = "R1";
        check(st, "ras_n", int'(ras_n), e_ras);
        check(st, "cas_n", int'(cas_n), e_cas);
        check(rt, "req", int'(req), e_req);
        check((!rst_n || cycle < 8) ? "R11" : "R9", "mode", int'(mode), e_mode);
        check((!rst_n || cycle < 8) ? "R11" : "R6", "owed_ovf", int'(owed_ovf), m_ovf);
    end

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cycle >= 20000) begin
            mismatched++;
            $display("FAIL watchdog: run did not end");
            finish_run();
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
        #2;
    endtask

    task automatic self_refresh(bit burst);
        burst_after_exit = burst;
        grant = 1; sr_enter_req = 1;
        while (mode == 2'd0) idle(1);
        sr_enter_req = 0;
        // R7: exit request during the entry hold must be ignored
        idle(3); sr_exit_req = 1; idle(1); sr_exit_req = 0;
        while (mode != 2'd2) idle(1);
        idle(45);                        // R8: no slots accrue in self refresh
        sr_exit_req = 1; idle(1); sr_exit_req = 0;
        if (burst) grant = 0;           // R10: burst needs no new grant
        idle(60);
        grant = 1;
    endtask

    initial begin
        idle(4);
        rst_n = 1;
        grant = 0;
        idle(100);                      // R5, R6: owed saturates, overflow flagged
        grant = 1; idle(80);            // R1, R3: backlog drains
        ext_mode = 1; idle(120);        // R2
        repeat (6) begin grant = ~grant; idle(7); end
        grant = 1; ext_mode = 0; idle(40);
        self_refresh(1'b0);             // R7, R8, R9
        idle(30);
        self_refresh(1'b1);             // R10
        repeat (10) begin grant = ~grant; idle(5); end
        grant = 1; idle(60);
        finish_run();
    end
endmodule